// File: doc/BRIEF.md
# Source Chunk Table Sequencer

This block walks a table of 32-bit chunk descriptors, one entry at a time, and turns each descriptor into one read request for the image buffer. A descriptor holds a source byte address and a byte count of 1 to 256 bytes. Entries are carried out strictly in table order, so software chooses the output order by the way it writes the table. It can reorder lines, repeat a line (vertical zoom) or leave a line out (vertical decimation). A rectangular region of interest is simply a table whose entries cover only that window. The block has no window logic of its own.

Software fills the table RAM and drives the number of entries to use on `entry_total`. It then pulses `start`. The sequencer reads entry 0 from the table RAM, which answers one cycle after the read strobe. It presents the decoded request and holds it until the image-buffer side acknowledges it. Only then does it fetch the next entry. After the last request has been accepted, `done` pulses for one cycle and the block returns to idle.

Top module: `src_table_seq`

## Requirements
- R1: While `rst_n` is low and in the cycles after it is released, `busy`, `done`, `tbl_rd_en` and `req_valid` are all 0.
- R2: An entry splits into two fields. Bits [31:8] give the source byte address and appear on `req_addr`. Bits [7:0] give the count minus one, so `req_len` = field + 1: field 0 gives 1 byte and field 255 gives 256 bytes.
- R3: After a start with N > 0 entries, the table is read at addresses 0, 1, ..., N-1 in that order. The requests appear in the same order, one per entry read.
- R4: The table is not read while a request is waiting for `req_ack`. The next entry is fetched only in the cycle after the acknowledge.
- R5: While `req_valid` is 1 and `req_ack` is 0, the next cycle keeps `req_valid` at 1 and leaves `req_addr` and `req_len` unchanged.
- R6: `entry_total` is sampled at the accepted start. Exactly that many requests are issued. `done` is 1 for exactly one cycle, the cycle after the last request is acknowledged.
- R7: A start with `entry_total` = 0 makes `done` high in the next cycle. No table read and no request take place.
- R8: A `start` pulse while `busy` is 1 is ignored. The run in progress keeps its entry count and its table position.
- R9: The table RAM is assumed to return `tbl_rd_data` in the cycle after `tbl_rd_en`. The request built from that data is valid two cycles after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run; accepted only while idle |
| entry_total | input | TBL_AW+1 | Number of table entries to use in the run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| tbl_rd_en | output | 1 | Table RAM read strobe |
| tbl_rd_addr | output | TBL_AW | Table RAM read address |
| tbl_rd_data | input | 32 | Table RAM read data, one cycle after the strobe |
| req_valid | output | 1 | Image-buffer read request is valid |
| req_addr | output | 24 | Source byte address of the chunk |
| req_len | output | 9 | Chunk length in bytes, 1 to 256 |
| req_ack | input | 1 | Image-buffer side accepts the request |

## Verification
The hardest situation to reach from the ports is a second `start` arriving in the middle of a run with a different `entry_total`. If it were accepted, the table position would be reset without any visible error. The bench pokes `start` with a full-table count right after a run has begun. It then checks that exactly the original number of entries is fetched and that `done` follows the original last entry. Every run length from 0 to the full table is swept, and the acknowledge is held back by 0, 1 or 2 cycles in a rotating pattern. This tests both the hold of a waiting request and the ban on fetching the next entry before the acknowledge. The table contents include the two extreme length codes, so the ends of the length field are tested too.

// File: rtl/src_seq_pkg.sv
// Package: shared types for the source chunk table sequencer.
// Holds the sequencer state encoding used by the control FSM.
package src_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_ISSUE,
        ST_FIN
    } seq_state_t;

endpackage

// File: rtl/src_seq_index.sv
// Module: src_seq_index
// Keeps the run length latched at start and the current table position.
// Assumes capture only occurs while idle and advance once per accepted request.
module src_seq_index #(
    parameter int TBL_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [TBL_AW:0]   total_in,
    input  logic              advance,
    output logic [TBL_AW-1:0] rd_addr,
    output logic              last,
    output logic              total_zero
);
    localparam int CW = TBL_AW + 1;

    logic [CW-1:0] total_q;
    logic [CW-1:0] pos_q;

    // Latch the run length at start and step the position on each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_q <= '0;
            pos_q   <= '0;
        end else if (capture) begin
            total_q <= total_in;
            pos_q   <= '0;
        end else if (advance) begin
            pos_q <= CW'(pos_q + 1'b1);
        end
    end

    assign rd_addr    = pos_q[TBL_AW-1:0];
    assign last       = (CW'(pos_q + 1'b1) == total_q);
    assign total_zero = (total_in == '0);

    // A request is only accepted for a position inside the latched run.
    p_pos_in_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (pos_q < total_q));

    // The run length is held for the whole run (start while busy ignored).
    p_total_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture && advance) |=> $stable(total_q));

endmodule

// File: rtl/src_seq_ctrl.sv
// Module: src_seq_ctrl
// Control FSM: idle -> fetch entry -> wait for RAM data -> issue request ->
// next entry or finish. Assumes a table RAM with one cycle of read latency.
module src_seq_ctrl
    import src_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic total_zero,
    input  logic last,
    input  logic req_ack,
    output logic capture,
    output logic rd_en,
    output logic load,
    output logic req_valid,
    output logic advance,
    output logic done,
    output logic busy
);
    seq_state_t state_q, state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (start) state_d = total_zero ? ST_FIN : ST_FETCH;
            ST_FETCH: state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_ISSUE;
            ST_ISSUE: if (req_ack) state_d = last ? ST_FIN : ST_FETCH;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign capture   = (state_q == ST_IDLE) && start;
    assign rd_en     = (state_q == ST_FETCH);
    assign load      = (state_q == ST_LOAD);
    assign req_valid = (state_q == ST_ISSUE);
    assign advance   = (state_q == ST_ISSUE) && req_ack;
    assign done      = (state_q == ST_FIN);
    assign busy      = (state_q != ST_IDLE);

    // done lasts exactly one cycle.
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // A table fetch follows either an accepted start or an acknowledge.
    p_fetch_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> ($past(capture) || $past(advance)));

endmodule

// File: rtl/src_seq_decode.sv
// Module: src_seq_decode
// Splits a table entry into address and length and registers the request.
// Assumes entry data is valid in the cycle that load is high.
module src_seq_decode #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [ADDR_W+CNT_W-1:0]   entry,
    input  logic                      valid,
    output logic [ADDR_W-1:0]         req_addr,
    output logic [CNT_W:0]            req_len
);
    localparam int LEN_W   = CNT_W + 1;
    localparam int MAX_LEN = 1 << CNT_W;

    // Capture the decoded entry; length field stores count minus one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_addr <= '0;
            req_len  <= '0;
        end else if (load) begin
            req_addr <= entry[ADDR_W+CNT_W-1:CNT_W];
            req_len  <= LEN_W'(entry[CNT_W-1:0]) + LEN_W'(1);
        end
    end

    // A valid request always carries 1..MAX_LEN bytes.
    p_len_bounds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((req_len != '0) && (int'(req_len) <= MAX_LEN)));

endmodule

// File: rtl/src_table_seq.sv
// Module: src_table_seq (top)
// Walks a descriptor table in order, issuing one image-buffer read request
// per entry and waiting for each acknowledge. Assumes a table RAM with one
// cycle of read latency and a requester that holds req_ack for one cycle.
module src_table_seq #(
    parameter int TBL_AW = 6,
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [TBL_AW:0]         entry_total,
    output logic                    busy,
    output logic                    done,
    output logic                    tbl_rd_en,
    output logic [TBL_AW-1:0]       tbl_rd_addr,
    input  logic [ADDR_W+CNT_W-1:0] tbl_rd_data,
    output logic                    req_valid,
    output logic [ADDR_W-1:0]       req_addr,
    output logic [CNT_W:0]          req_len,
    input  logic                    req_ack
);
    logic capture, load, advance, last, total_zero;

    src_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .total_zero (total_zero),
        .last       (last),
        .req_ack    (req_ack),
        .capture    (capture),
        .rd_en      (tbl_rd_en),
        .load       (load),
        .req_valid  (req_valid),
        .advance    (advance),
        .done       (done),
        .busy       (busy)
    );

    src_seq_index #(.TBL_AW(TBL_AW)) u_index (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .total_in   (entry_total),
        .advance    (advance),
        .rd_addr    (tbl_rd_addr),
        .last       (last),
        .total_zero (total_zero)
    );

    src_seq_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .entry    (tbl_rd_data),
        .valid    (req_valid),
        .req_addr (req_addr),
        .req_len  (req_len)
    );

    // A waiting request keeps its contents until acknowledged.
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_addr) && $stable(req_len)));

    // done follows either the last acknowledge or a zero-length start.
    p_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(req_valid && req_ack) || $past(start && !busy)));

    // No table read while a request is outstanding.
    p_no_fetch_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !tbl_rd_en);

endmodule

// File: tb/src_table_seq_test.sv
// Bench: sweeps every run length of a 16-entry table with rotating ack delays.
module src_table_seq_test;
    localparam int TAW   = 4;
    localparam int DEPTH = 1 << TAW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst_n, start, req_ack;
    logic [TAW:0]   entry_total;
    logic           busy, done, tbl_rd_en, req_valid;
    logic [TAW-1:0] tbl_rd_addr;
    logic [31:0]    tbl_rd_data;
    logic [23:0]    req_addr;
    logic [8:0]     req_len;

    logic [31:0] mem [DEPTH];
    int checks = 0;
    int fails  = 0;
    int fetch_exp = 0;

    src_table_seq #(.TBL_AW(TAW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .entry_total(entry_total),
        .busy(busy), .done(done), .tbl_rd_en(tbl_rd_en), .tbl_rd_addr(tbl_rd_addr),
        .tbl_rd_data(tbl_rd_data), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_ack(req_ack)
    );

    // Table RAM model: one cycle of read latency (R9).
    always @(posedge clk) if (tbl_rd_en) tbl_rd_data <= mem[tbl_rd_addr];

    function automatic int exp_addr(int i);
        return (i * 'h1234 + 'h100) & 'hFFFFFF;
    endfunction

    function automatic int exp_lf(int i);
        if (i == 0) return 0;
        if (i == 1) return 255;
        return (i * 37 + 5) & 255;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Table read order monitor (R3).
    always @(negedge clk) begin
        if (rst_n && tbl_rd_en) begin
            chk(int'(tbl_rd_addr) == fetch_exp, "R3", "table read address", tbl_rd_addr, fetch_exp);
            fetch_exp++;
        end
    end

    task automatic run(int n, int seed, bit poke);
        @(negedge clk);
        fetch_exp   = 0;
        entry_total = (TAW+1)'(n);
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            chk(done == 1'b1, "R7", "done after zero start", done, 1);
            @(negedge clk);
            chk(done == 1'b0 && !req_valid, "R7", "quiet after zero run", {done, req_valid}, 0);
            chk(fetch_exp == 0, "R7", "table reads", fetch_exp, 0);
            return;
        end
        if (poke) begin
            entry_total = (TAW+1)'(DEPTH);
            start       = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int k = 0; k < n; k++) begin
            int w = 0;
            while (!req_valid && w < 20) begin
                @(negedge clk);
                w++;
            end
            chk(req_valid == 1'b1, "R3", "request appears", req_valid, 1);
            chk(int'(req_addr) == exp_addr(k), "R2", "req_addr", req_addr, exp_addr(k));
            chk(int'(req_len) == exp_lf(k) + 1, "R2", "req_len", req_len, exp_lf(k) + 1);
            for (int j = 0; j < (k + seed) % 3; j++) begin
                logic [23:0] a0 = req_addr;
                logic [8:0]  l0 = req_len;
                @(negedge clk);
                chk(req_valid && req_addr == a0 && req_len == l0, "R5", "held request",
                    {req_valid, req_addr}, {1'b1, a0});
                chk(!tbl_rd_en, "R4", "no fetch while pending", tbl_rd_en, 0);
            end
            req_ack = 1'b1;
            @(negedge clk);
            req_ack = 1'b0;
            if (k < n - 1) begin
                chk(!req_valid && !done, "R4", "request dropped after ack", {req_valid, done}, 0);
                chk(tbl_rd_en == 1'b1, "R4", "fetch right after ack", tbl_rd_en, 1);
            end
        end
        chk(done == 1'b1, "R6", "done after last ack", done, 1);
        @(negedge clk);
        chk(!done && !req_valid && !busy, "R6", "single done pulse", {done, req_valid, busy}, 0);
        chk(fetch_exp == n, poke ? "R8" : "R6", "entries fetched", fetch_exp, n);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = {exp_addr(i)[23:0], exp_lf(i)[7:0]};
        rst_n = 1'b0; start = 1'b0; req_ack = 1'b0; entry_total = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !tbl_rd_en && !req_valid, "R1", "outputs in reset",
            {busy, done, tbl_rd_en, req_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !tbl_rd_en && !req_valid, "R1", "outputs after reset",
            {busy, done, tbl_rd_en, req_valid}, 0);
        for (int n = 0; n <= DEPTH; n++)
            for (int s = 0; s < 3; s++)
                run(n, s, (s == 1) && (n > 0));
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule